// File: doc/BRIEF.md
# Bus Tenure Dwell Limiter

This block sits beside a DMA engine's bus interface and decides when the engine should give the bus back after the arbiter has granted it. While the grant is held, it counts the transactions that complete and the clock cycles that pass. It compares both counts with two limits packed into one 16-bit configuration word. Reaching either limit marks the end of a burst.

A separate 2-bit rule decides what ends a tenure. The tenure can end when demand ends, meaning the DMA request is low at a completed transaction. It can end when the burst ends. It can also end on either of the two.

The release request is raised only at a completed transaction, never in the middle of one. A transaction held open by the wait input runs to its end even when the cycle budget runs out while it is stalled. The request stays high until the grant is withdrawn. Every count restarts when the next grant begins.

Top module: `bus_dwell_limiter`

## Requirements
- R1: While `rst_n` is low, `release_req` is 0. In any cycle after a clock edge at which `grant` was low, `release_req` is 0 and both counts restart from zero.
- R2: `dwell_cfg[15:8]` is a binary transaction limit N. When N is nonzero, the N-th completed transaction of a tenure is a burst end.
- R3: A transaction limit of 0 disables the transaction limit.
- R4: `dwell_cfg[7:0]` is a cycle limit L in units of 8 clocks. A completed transaction is a burst end when at least 8·L granted cycles have already passed. Between transactions no release is raised.
- R5: A cycle limit of 0 disables the cycle limit.
- R6: A done strobe while `bus_wait` is high neither completes nor counts a transaction. The transaction completes at the first done strobe with `bus_wait` low, even if a limit expired during the stall.
- R7: A done strobe counts only for a transaction that was started by `xfer_start`, either in an earlier cycle or in the same cycle. A stray done strobe is ignored.
- R8: With `end_rule` = 00, only a demand end releases: `dma_req` low at a completed transaction. The limits are ignored.
- R9: With `end_rule` = 01, and with the reserved value 11, either a demand end or a burst end releases.
- R10: With `end_rule` = 10, only a burst end releases. `dma_req` going low has no effect.
- R11: `release_req` rises one cycle after the clock edge of the qualifying completion. It stays high while `grant` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant | input | 1 | Bus granted to the DMA engine |
| xfer_start | input | 1 | Strobe: a bus transaction begins |
| xfer_done | input | 1 | Strobe: a bus transaction ends |
| bus_wait | input | 1 | External stall; a done strobe is void while high |
| dma_req | input | 1 | DMA request line |
| dwell_cfg | input | 16 | [15:8] transaction limit, [7:0] cycle limit in 8-clock units |
| end_rule | input | 2 | 00 demand end, 01 either, 10 burst end, 11 treated as 01 |
| release_req | output | 1 | Request to give up the bus |

## Verification
`release_req` is a registered output. A qualifying completion sampled at clock edge k shows at the output after edge k. A grant sampled low at edge k clears the output after edge k. The bench applies each stimulus at the falling edge and works out the expected output from the requirements at that moment. It queues that value, and a monitor pops the value and compares it with `release_req` 1 ns after the next rising edge. In this way every cycle of every scenario is compared exactly one register stage after its stimulus.

// File: rtl/bus_dwell_limiter.sv
module bus_dwell_limiter #(
  parameter int LIM_W     = 8,
  parameter int GRAN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  logic               xfer_start,
  input  logic               xfer_done,
  input  logic               bus_wait,
  input  logic               dma_req,
  input  logic [2*LIM_W-1:0] dwell_cfg,
  input  logic [1:0]         end_rule,
  output logic               release_req
);
  localparam int CYC_W = LIM_W + GRAN_LOG2;

  logic [LIM_W-1:0] xfer_lim, cyc_lim, xfers;
  logic [CYC_W-1:0] cycles;
  logic             busy, done_ok, xfer_met, cyc_met, burst_end, demand_end, stop;

  assign xfer_lim   = dwell_cfg[2*LIM_W-1:LIM_W];
  assign cyc_lim    = dwell_cfg[LIM_W-1:0];
  assign done_ok    = grant && xfer_done && !bus_wait && (busy || xfer_start);
  assign xfer_met   = (xfer_lim != '0) && (({1'b0, xfers} + 1'b1) >= {1'b0, xfer_lim});
  assign cyc_met    = (cyc_lim != '0) && (cycles >= {cyc_lim, {GRAN_LOG2{1'b0}}});
  assign burst_end  = xfer_met || cyc_met;
  assign demand_end = !dma_req;

  always_comb begin
    case (end_rule)
      2'b00:   stop = demand_end;
      2'b10:   stop = burst_end;
      default: stop = demand_end || burst_end;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; xfers <= '0; cycles <= '0; release_req <= 1'b0;
    end else if (!grant) begin
      busy <= 1'b0; xfers <= '0; cycles <= '0; release_req <= 1'b0;
    end else begin
      if (cycles != '1) cycles <= cycles + 1'b1;
      if (done_ok) begin
        busy <= 1'b0;
        if (xfers != '1) xfers <= xfers + 1'b1;
        if (stop) release_req <= 1'b1;
      end else if (xfer_start) begin
        busy <= 1'b1;
      end
    end
  end

  assert_clear_when_ungranted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> !release_req);
  assert_release_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_req) |-> $past(done_ok));
  assert_not_during_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_req) |-> !$past(bus_wait));
  assert_demand_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(release_req) && $past(end_rule) == 2'b00) |-> !$past(dma_req));
  assert_sticky_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (release_req && grant) |=> release_req);
endmodule

// File: tb/bus_dwell_limiter_bench.sv
module bus_dwell_limiter_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic g = 0, s = 0, d = 0, st = 0, rq = 0;
  logic [15:0] cfg = '0;
  logic [1:0]  rule = 2'b00;
  logic        release_req;
  int checks = 0, errors = 0;
  bit done_flag = 0;
  string tag = "R1";

  logic  q_exp[$];
  string q_tag[$];

  logic m_busy = 0, m_rel = 0;
  int   m_x = 0, m_c = 0;

  always #2 clk = ~clk;

  bus_dwell_limiter u_bus_dwell_limiter (
    .clk(clk), .rst_n(rst_n), .grant(g), .xfer_start(s), .xfer_done(d),
    .bus_wait(st), .dma_req(rq), .dwell_cfg(cfg), .end_rule(rule),
    .release_req(release_req));

  task automatic tick(input logic tg, ts, td, tst, trq);
    int tl, cl;
    logic ok, burst, dem, trig;
    @(negedge clk);
    g = tg; s = ts; d = td; st = tst; rq = trq;
    tl = int'(cfg[15:8]); cl = int'(cfg[7:0]);
    if (!tg) begin
      m_busy = 0; m_x = 0; m_c = 0; m_rel = 0;
    end else begin
      ok    = td && !tst && (m_busy || ts);
      burst = (tl != 0 && m_x + 1 >= tl) || (cl != 0 && m_c >= cl * 8);
      dem   = !trq;
      case (rule)
        2'b00:   trig = dem;
        2'b10:   trig = burst;
        default: trig = dem || burst;
      endcase
      if (ok && trig) m_rel = 1;
      if (ok) m_busy = 0; else if (ts) m_busy = 1;
      if (ok && m_x < 255) m_x++;
      if (m_c < 2047) m_c++;
    end
    q_exp.push_back(m_rel);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input logic trq);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0, trq);
  endtask

  task automatic xfer(input logic trq);
    tick(1, 1, 0, 0, trq);
    tick(1, 0, 1, 0, trq);
  endtask

  task automatic drop(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 1);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q_exp.size() > 0) begin
      logic e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (release_req !== e) begin
        errors++;
        $display("FAIL %s: release_req=%b expected %b at %0t", t, release_req, e, $time);
      end
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (release_req !== 1'b0) begin
        errors++;
        $display("FAIL R1: release_req=%b expected 0 in reset", release_req);
      end
    end
    @(negedge clk); rst_n = 1;

    tag = "R1"; drop(3);
    tag = "R2"; cfg = {8'd3, 8'd0}; rule = 2'b10;
    xfer(1); idle(2, 1); xfer(1); xfer(1); idle(2, 1);
    tag = "R11"; xfer(1); idle(3, 1);
    tag = "R1"; drop(2);
    tag = "R11"; xfer(1); xfer(1); idle(1, 1); xfer(1); idle(1, 1); drop(2);

    tag = "R3"; cfg = 16'h0000;
    for (int i = 0; i < 6; i++) xfer(1);
    idle(3, 1); drop(2);

    tag = "R4"; cfg = {8'd0, 8'd2};
    xfer(1); idle(4, 1); xfer(1); idle(12, 1); idle(2, 1); xfer(1); idle(2, 1); drop(2);
    tag = "R6"; cfg = {8'd0, 8'd2};
    xfer(1); idle(5, 1); tick(1, 1, 0, 0, 1);
    for (int i = 0; i < 10; i++) tick(1, 0, (i == 5), 1, 1);
    tick(1, 0, 1, 1, 1); tick(1, 0, 1, 0, 1); idle(2, 1); drop(2);

    tag = "R5"; cfg = 16'h0000;
    idle(30, 1); xfer(1); idle(15, 1); xfer(1); idle(2, 1); drop(2);

    tag = "R7"; cfg = {8'd1, 8'd0}; rule = 2'b10;
    tick(1, 0, 1, 0, 1); idle(2, 1); tick(1, 0, 1, 0, 1); idle(1, 1);
    tick(1, 1, 1, 0, 1); idle(2, 1); drop(2);

    tag = "R8"; cfg = {8'd1, 8'd1}; rule = 2'b00;
    xfer(1); idle(10, 1); xfer(1); xfer(1); idle(1, 0); xfer(0); idle(2, 1); drop(2);

    tag = "R9"; cfg = {8'd2, 8'd0}; rule = 2'b01;
    xfer(1); idle(1, 1); xfer(1); idle(2, 1); drop(2);
    xfer(0); idle(2, 1); drop(2);
    rule = 2'b11;
    xfer(1); xfer(1); idle(2, 1); drop(2);
    xfer(0); idle(2, 1); drop(2);

    tag = "R10"; cfg = 16'h0000; rule = 2'b10;
    xfer(0); xfer(0); idle(3, 0); drop(1);
    cfg = {8'd2, 8'd0}; xfer(0); xfer(0); idle(2, 0); drop(2);

    @(posedge clk); #2;
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule